// File: doc/BRIEF.md
# BER Performance Seconds Accumulator

This block turns a raw stream of per-bit comparison results into link performance counts. The pattern checker upstream delivers four things each clock: a received-bit enable, a bit-error strobe, a pattern-lock flag, and interval ticks for one second and one minute. The block sorts every second and every minute by its error ratio. It also keeps running counts of bit errors, loss-of-lock events and seconds, and available and unavailable time.

Each ratio threshold is checked with an integer compare, errors times a denominator against bits. The block never divides. A second counts as bad when its errors times 1000 exceed its bits. A run of ten bad seconds turns unavailable as a whole, backdated to its first second. Bad seconds that stay in a shorter run are held back. They are credited as available once a good second ends the run. Software reads any counter through a select/data port and zeroes all of them with a single clear strobe. Percentages are left to software.

Top module: `ber_perf_accum`

## Requirements
- R1: The bit-error count increments by one on each cycle where bit_en_i, bit_err_i and sync_i are all high. When sync_i is low, errored bits leave it unchanged.
- R2: A second is in sync when sync_i stays high on every cycle from the first cycle after the previous tick up to and including the tick cycle. At its tick, an in-sync second with a nonzero error count adds one to the errored-seconds count, and an in-sync second with no errors adds one to the error-free-seconds count. A second that is not in sync adds to neither.
- R3: At a second tick, the severely-errored-seconds count increments when errors × SES_DEN > bits for that second (default SES_DEN = 1000). This holds regardless of sync.
- R4: At a minute tick, the degraded-minutes count increments when the minute's error count is nonzero and errors × DM_DEN ≥ bits (default DM_DEN = 1,000,000).
- R5: The loss-of-sync event count increments once for each high-to-low transition of sync_i.
- R6: The loss-of-sync seconds count increments by one at a second tick if sync_i fell one or more times in that second.
- R7: A second that is not severely errored counts as available. Bad seconds in an unfinished run of fewer than ten are held pending. When a good second closes such a run, the available count grows by the pending count plus one.
- R8: When the tenth consecutive bad second ends, the unavailable count grows by ten and the block enters the unavailable state. Each further bad second adds one. The first good second adds one to the available count and leaves the unavailable state.
- R9: Every counter saturates at all ones and stays there until cleared.
- R10: Reset or a clear_i pulse zeroes all counters, the in-progress intervals and the pending run on the next edge. clear_i takes priority over any tick in the same cycle.
- R11: rd_sel_i picks the counter shown on rd_data_o: 0 bit errors, 1 errored s, 2 error-free s, 3 severely errored s, 4 degraded min, 5 loss-of-sync events, 6 loss-of-sync s, 7 available s, 8 unavailable s. Codes 9 to 15 read zero.
- R12: A bit presented in the same cycle as a tick belongs to the interval that ends. The next interval starts empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all statistics |
| bit_en_i | input | 1 | A received bit is compared this cycle |
| bit_err_i | input | 1 | The compared bit was wrong |
| sync_i | input | 1 | Pattern lock flag |
| sec_tick_i | input | 1 | One-cycle pulse ending a second |
| min_tick_i | input | 1 | One-cycle pulse ending a minute |
| rd_sel_i | input | 4 | Counter select |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
Every internal fault in this block shows up at the read port after at most one second tick. A wrong bit or error total in an interval, or a wrong pending-run length, miscounts the severe, available or unavailable totals at the boundary it affects. A fault that merges the ten-second window appears as a jump of ten in the wrong counter, or no jump, at exactly the tenth bad tick. The threshold compares are driven to their equality points, where an off-by-one flips the count on the same tick.

// File: rtl/ber_perf_pkg.sv
package ber_perf_pkg;
  localparam int NUM_CNT = 9;
  localparam int SEL_W   = 4;
  localparam int RUN_LEN = 10;
  localparam int AMT_W   = $clog2(RUN_LEN + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_BIT_ERR  = 4'd0,
    SEL_ES       = 4'd1,
    SEL_EFS      = 4'd2,
    SEL_SES      = 4'd3,
    SEL_DM       = 4'd4,
    SEL_LOS_EVT  = 4'd5,
    SEL_LOS_SEC  = 4'd6,
    SEL_AVAIL    = 4'd7,
    SEL_UNAVAIL  = 4'd8
  } cnt_sel_e;
endpackage

// File: rtl/bpa_sat_cnt.sv
module bpa_sat_cnt
  import ber_perf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W + 1)'(amt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= sum[CNT_W] ? MAX : sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clear_i) |=> cnt_q == MAX); // R9
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0); // R10
  AST_INC_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && amt_i != '0 && !clear_i && cnt_q != MAX) |=> cnt_q > $past(cnt_q)); // R9
endmodule

// File: rtl/bpa_interval.sv
module bpa_interval #(
  parameter int INTV_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  input  logic              bit_en_i,
  input  logic              bit_err_i,
  output logic [INTV_W-1:0] bits_o,
  output logic [INTV_W-1:0] errs_o
);
  logic [INTV_W-1:0] bits_q, errs_q;

  // totals including this cycle's bit
  always_comb begin
    bits_o = bits_q;
    errs_o = errs_q;
    if (bit_en_i && bits_q != '1)              bits_o = bits_q + 1'b1;
    if (bit_en_i && bit_err_i && errs_q != '1) errs_o = errs_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      errs_q <= '0;
    end else if (clear_i || tick_i) begin
      bits_q <= '0;
      errs_q <= '0;
    end else begin
      bits_q <= bits_o;
      errs_q <= errs_o;
    end
  end

  AST_INTV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i || clear_i) |=> (bits_q == '0 && errs_q == '0)); // R12
  AST_ERRS_LE_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    errs_q <= bits_q); // R12
endmodule

// File: rtl/bpa_avail_fsm.sv
module bpa_avail_fsm
  import ber_perf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             bad_i,
  output logic             avail_inc_o,
  output logic [AMT_W-1:0] avail_amt_o,
  output logic             unav_inc_o,
  output logic [AMT_W-1:0] unav_amt_o
);
  logic [AMT_W-1:0] run_q, run_d;
  logic             unav_q, unav_d;

  always_comb begin
    run_d       = run_q;
    unav_d      = unav_q;
    avail_inc_o = 1'b0;
    avail_amt_o = '0;
    unav_inc_o  = 1'b0;
    unav_amt_o  = '0;
    if (tick_i) begin
      if (!bad_i) begin
        avail_inc_o = 1'b1;
        avail_amt_o = unav_q ? AMT_W'(1) : run_q + 1'b1;
        run_d       = '0;
        unav_d      = 1'b0;
      end else if (unav_q) begin
        unav_inc_o  = 1'b1;
        unav_amt_o  = AMT_W'(1);
      end else if (run_q == AMT_W'(RUN_LEN - 1)) begin
        // backdate the whole run
        unav_inc_o  = 1'b1;
        unav_amt_o  = AMT_W'(RUN_LEN);
        run_d       = '0;
        unav_d      = 1'b1;
      end else begin
        run_d       = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      unav_q <= 1'b0;
    end else if (clear_i) begin
      run_q  <= '0;
      unav_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      unav_q <= unav_d;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < AMT_W'(RUN_LEN)); // R8
  AST_UNAV_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && bad_i && !unav_q && run_q == AMT_W'(RUN_LEN - 1) && !clear_i) |=> unav_q); // R8
  AST_RUN_ONLY_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unav_q |-> run_q == '0); // R7
endmodule

// File: rtl/ber_perf_accum.sv
module ber_perf_accum
  import ber_perf_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int INTV_W  = 32,
  parameter int SES_DEN = 1000,
  parameter int DM_DEN  = 1000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             bit_en_i,
  input  logic             bit_err_i,
  input  logic             sync_i,
  input  logic             sec_tick_i,
  input  logic             min_tick_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic [INTV_W-1:0] s_bits, s_errs, m_bits, m_errs;
  logic              sync_q, sync_fall;
  logic              sec_ok_q, sec_ok, los_seen_q;
  logic              sec_bad, min_bad;
  logic              av_inc, ua_inc;
  logic [AMT_W-1:0]  av_amt, ua_amt;

  logic [NUM_CNT-1:0] inc;
  logic [AMT_W-1:0]   amt [NUM_CNT];
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  bpa_interval #(.INTV_W(INTV_W)) u_sec (
    .clk_i, .rst_ni, .clear_i, .tick_i(sec_tick_i),
    .bit_en_i, .bit_err_i, .bits_o(s_bits), .errs_o(s_errs)
  );

  bpa_interval #(.INTV_W(INTV_W)) u_min (
    .clk_i, .rst_ni, .clear_i, .tick_i(min_tick_i),
    .bit_en_i, .bit_err_i, .bits_o(m_bits), .errs_o(m_errs)
  );

  assign sync_fall = sync_q & ~sync_i;
  assign sec_ok    = sec_ok_q & sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= 1'b0;
      sec_ok_q   <= 1'b1;
      los_seen_q <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (clear_i || sec_tick_i) begin
        sec_ok_q   <= 1'b1;
        los_seen_q <= 1'b0;
      end else begin
        sec_ok_q   <= sec_ok;
        los_seen_q <= los_seen_q | sync_fall;
      end
    end
  end

  assign sec_bad = (64'(s_errs) * 64'(SES_DEN)) > 64'(s_bits);
  assign min_bad = (m_errs != '0) && ((64'(m_errs) * 64'(DM_DEN)) >= 64'(m_bits));

  bpa_avail_fsm u_avail (
    .clk_i, .rst_ni, .clear_i, .tick_i(sec_tick_i), .bad_i(sec_bad),
    .avail_inc_o(av_inc), .avail_amt_o(av_amt),
    .unav_inc_o(ua_inc), .unav_amt_o(ua_amt)
  );

  always_comb begin
    inc                    = '0;
    for (int k = 0; k < NUM_CNT; k++) amt[k] = AMT_W'(1);
    inc[int'(SEL_BIT_ERR)] = bit_en_i & bit_err_i & sync_i;
    inc[int'(SEL_ES)]      = sec_tick_i & sec_ok & (s_errs != '0);
    inc[int'(SEL_EFS)]     = sec_tick_i & sec_ok & (s_errs == '0);
    inc[int'(SEL_SES)]     = sec_tick_i & sec_bad;
    inc[int'(SEL_DM)]      = min_tick_i & min_bad;
    inc[int'(SEL_LOS_EVT)] = sync_fall;
    inc[int'(SEL_LOS_SEC)] = sec_tick_i & (los_seen_q | sync_fall);
    inc[int'(SEL_AVAIL)]   = av_inc;
    amt[int'(SEL_AVAIL)]   = av_amt;
    inc[int'(SEL_UNAVAIL)] = ua_inc;
    amt[int'(SEL_UNAVAIL)] = ua_amt;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    bpa_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clear_i,
      .inc_i(inc[g]), .amt_i(amt[g]), .cnt_o(cnt[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (rd_sel_i == SEL_W'(k)) rd_data_o = cnt[k];
  end

  AST_ES_EFS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inc[int'(SEL_ES)], inc[int'(SEL_EFS)]})); // R2
  AST_NO_ERR_OUT_OF_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !clear_i) |=> $stable(cnt[int'(SEL_BIT_ERR)])); // R1
  AST_LOS_SEC_LE_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !clear_i && !los_seen_q && !sync_fall)
      |=> $stable(cnt[int'(SEL_LOS_SEC)])); // R6
  AST_AVAIL_XOR_UNAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({av_inc, ua_inc})); // R7
endmodule

// File: tb/ber_perf_accum_tb_top.sv
module ber_perf_accum_tb_top;
  localparam int CNT_W = 8;
  localparam int NBITS = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, bit_en = 1'b0, bit_err = 1'b0, sync = 1'b0;
  logic       sec_tick = 1'b0, min_tick = 1'b0;
  logic [3:0] rd_sel = '0;
  logic [CNT_W-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ber_perf_accum #(.CNT_W(CNT_W), .INTV_W(16), .SES_DEN(1000), .DM_DEN(1000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .bit_en_i(bit_en),
    .bit_err_i(bit_err), .sync_i(sync), .sec_tick_i(sec_tick),
    .min_tick_i(min_tick), .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );

  // columns: errors in second, expected available, unavailable, severe
  localparam int VEC [16][4] = '{
    '{0, 1, 0, 0},  '{2, 2, 0, 0},  '{3, 2, 0, 1},  '{0, 4, 0, 1},
    '{5, 4, 0, 2},  '{5, 4, 0, 3},  '{5, 4, 0, 4},  '{5, 4, 0, 5},
    '{5, 4, 0, 6},  '{5, 4, 0, 7},  '{5, 4, 0, 8},  '{5, 4, 0, 9},
    '{5, 4, 0, 10}, '{5, 4, 10, 11}, '{5, 4, 11, 12}, '{0, 5, 11, 12}
  };

  task automatic chk(string req, int sel, int exp_v);
    rd_sel = sel[3:0];
    #1;
    n_chk++;
    if (int'(rd_data) != exp_v) begin
      n_fail++;
      $display("FAIL %s sel=%0d actual=%0d expected=%0d", req, sel, rd_data, exp_v);
    end
  endtask

  task automatic run_bits(int n, int e);
    for (int i = 0; i < n; i++) begin
      bit_en = 1'b1;
      bit_err = (i < e);
      @(negedge clk);
    end
    bit_en = 1'b0;
    bit_err = 1'b0;
  endtask

  task automatic pulse_sec();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic pulse_min();
    min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    int es, efs, tot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int s = 0; s < 9; s++) chk("R10 reset", s, 0);

    sync = 1'b1;
    @(negedge clk);
    do_clear();

    es = 0; efs = 0; tot = 0;
    for (int v = 0; v < 16; v++) begin
      run_bits(NBITS, VEC[v][0]);
      pulse_sec();
      tot += VEC[v][0];
      if (VEC[v][0] != 0) es++; else efs++;
      chk("R7 avail", 7, VEC[v][1]);
      chk("R8 unavail", 8, VEC[v][2]);
      chk("R3 severe", 3, VEC[v][3]);
      chk("R2 errored s", 1, es);
      chk("R2 error-free s", 2, efs);
    end
    chk("R1 total", 0, tot);
    chk("R5 no fall", 5, 0);
    chk("R6 no lost s", 6, 0);

    // R11 unused select codes
    for (int s = 9; s < 16; s++) chk("R11 unused sel", s, 0);

    // R10 clear with a tick in the same cycle
    run_bits(10, 10);
    clear = 1'b1; sec_tick = 1'b1; min_tick = 1'b1;
    @(negedge clk);
    clear = 1'b0; sec_tick = 1'b0; min_tick = 1'b0;
    for (int s = 0; s < 9; s++) chk("R10 clear", s, 0);

    // R4 degraded minute, equality boundary
    run_bits(NBITS, 2);
    pulse_min();
    chk("R4 dm equal", 4, 1);
    run_bits(NBITS, 1);
    pulse_min();
    chk("R4 dm below", 4, 1);
    pulse_min();
    chk("R4 dm empty", 4, 1);

    // R1 errors ignored out of sync
    do_clear();
    sync = 1'b0;
    run_bits(5, 5);
    chk("R1 out of sync", 0, 0);
    sync = 1'b1;
    run_bits(3, 3);
    chk("R1 in sync", 0, 3);

    // R5 R6 two drops in one second
    do_clear();
    @(negedge clk);
    sync = 1'b0; @(negedge clk); @(negedge clk);
    sync = 1'b1; @(negedge clk);
    sync = 1'b0; @(negedge clk);
    sync = 1'b1; @(negedge clk);
    pulse_sec();
    chk("R5 events", 5, 2);
    chk("R6 lost s", 6, 1);
    chk("R2 not in sync es", 1, 0);
    chk("R2 not in sync efs", 2, 0);
    pulse_sec();
    chk("R6 clean s", 6, 1);
    chk("R2 clean efs", 2, 1);

    // R12 tick-cycle bit belongs to ending second
    do_clear();
    run_bits(NBITS - 1, 2);
    bit_en = 1'b1; bit_err = 1'b0; sec_tick = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; sec_tick = 1'b0;
    chk("R12 tick bit", 3, 0);
    chk("R12 tick bit es", 1, 1);
    pulse_sec();
    chk("R12 fresh second", 2, 1);

    // R9 saturation
    do_clear();
    run_bits(300, 300);
    chk("R9 saturate", 0, 255);
    run_bits(4, 4);
    chk("R9 hold", 0, 255);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule